// File: doc/BRIEF.md
# Sixteen-Entry Match Table with Selectable Reporting

This block holds a small table of byte-wide words, each with its own valid bit. A search key is compared against every valid word in a single cycle. The result is registered and reported in one of two ways. In single mode it gives the lowest-numbered matching slot as an encoded index, with that slot also shown as a one-hot vector. In multiple mode it gives a vector with one bit per matching slot and a count of the hits. Slots are filled through a plain write port. A slot can be invalidated on its own, or every slot can be invalidated at once. Contents can be preloaded through parameters and take effect at reset.

Searches flow through a valid/ready pair, and so do results. A key is accepted on any cycle where `srch_valid` and `srch_ready` are both high. Its result appears on the next cycle with `res_valid` high. A result stays on the outputs, unchanged, until `res_ready` is seen high. While a result is pending and `res_ready` is low, `srch_ready` is low. Once the consumer takes the result, `srch_ready` rises in the same cycle, so a new key can be accepted at once. The write and clear pins are plain control inputs and are always accepted.

Top module: `cam_match_unit`

## Requirements
- R1: After reset `res_valid` is 0, `srch_ready` is 1, and every result field (`res_hit`, `res_addr`, `res_vec`, `res_count`) is 0.
- R2: When `wr_en` is high, `wr_data` is stored in slot `wr_addr` and that slot becomes valid. A search accepted in the same cycle as the write still sees the old contents. A search accepted in the following cycle sees the new contents.
- R3: A slot whose valid bit is 0 never matches, whatever data it holds.
- R4: In single mode (`srch_multi`=0), `res_addr` is the lowest matching slot index and `res_hit` is 1. `res_vec` has only bit `res_addr` set, and `res_count` is 1.
- R5: In multiple mode (`srch_multi`=1), bit i of `res_vec` is 1 exactly when slot i is valid and equals the key. `res_count` is the number of set bits, `res_addr` is the lowest such index, and `res_hit` is 1 when any bit is set.
- R6: When no valid slot matches, in either mode, `res_hit`, `res_addr`, `res_vec` and `res_count` are all 0.
- R7: `clr_en` invalidates slot `clr_addr`. If a write to the same slot happens in the same cycle, the clear wins and the slot ends up invalid.
- R8: `clr_all` invalidates every slot in one cycle and overrides any write or single clear in that cycle.
- R9: A key accepted at clock edge t has its result on the outputs, with `res_valid` high, right after edge t+1's preceding edge, that is, in the cycle after acceptance.
- R10: While `res_valid` is 1 and `res_ready` is 0, `srch_ready` is 0 and every result output holds its value. `res_valid` falls after an edge where `res_ready` was 1 and no new key was accepted.
- R11: At reset, slot i takes data `INIT_WORDS[i*WIDTH +: WIDTH]` and valid bit `INIT_VALID[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Slot index for a write |
| wr_data | input | 8 | Word to store |
| clr_en | input | 1 | Invalidate one slot |
| clr_addr | input | 4 | Slot index for a single clear |
| clr_all | input | 1 | Invalidate all slots |
| srch_valid | input | 1 | Search key offered |
| srch_ready | output | 1 | Search key can be taken |
| srch_key | input | 8 | Key to compare |
| srch_multi | input | 1 | 1 selects multiple mode, 0 selects single mode |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes result |
| res_hit | output | 1 | At least one match |
| res_addr | output | 4 | Lowest matching slot |
| res_vec | output | 16 | Per-slot match vector |
| res_count | output | 5 | Number of bits set in res_vec |

## Verification
A wrong valid bit or stored word inside the table shows up at the ports on the first search that uses that key. It appears in the cycle after the key is accepted, as a wrong bit in `res_vec`, a wrong count, or a different lowest index. A stuck result register or a broken hold shows up during back-pressure as a changed output or a `srch_ready` that stays high. The bench keeps its own model of the table and compares every output on every cycle, so such a fault is caught within one clock of the first search that exposes it.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic {
    MATCH_SINGLE = 1'b0,
    MATCH_MULTI  = 1'b1
  } match_mode_e;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  parameter logic [DEPTH*WIDTH-1:0] INIT_WORDS = '0,
  parameter logic [DEPTH-1:0] INIT_VALID = '0,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [WIDTH-1:0]       wr_data,
  input  logic                   clr_en,
  input  logic [AW-1:0]          clr_addr,
  input  logic                   clr_all,
  output logic [DEPTH*WIDTH-1:0] ent_data,
  output logic [DEPTH-1:0]       ent_valid
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic kill, load;
    assign kill = clr_all || (clr_en && (clr_addr == AW'(i)));
    assign load = wr_en && (wr_addr == AW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_data[i*WIDTH +: WIDTH] <= INIT_WORDS[i*WIDTH +: WIDTH];
        ent_valid[i]               <= INIT_VALID[i];
      end else if (kill) begin
        ent_valid[i] <= 1'b0;
      end else if (load) begin
        ent_data[i*WIDTH +: WIDTH] <= wr_data;
        ent_valid[i]               <= 1'b1;
      end
    end

    // R7: a single clear leaves the slot invalid, even against a write
    a_r7_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_addr == AW'(i)) |=> !ent_valid[i]);
  end

  // R8: clear-all empties the table in one cycle
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (ent_valid == '0));
endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8
) (
  input  logic [DEPTH*WIDTH-1:0] ent_data,
  input  logic [DEPTH-1:0]       ent_valid,
  input  logic [WIDTH-1:0]       key,
  output logic [DEPTH-1:0]       hits
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hits[i] = ent_valid[i] && (ent_data[i*WIDTH +: WIDTH] == key);
  end
endmodule

// File: rtl/cam_encode.sv
module cam_encode #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] hits,
  output logic             any,
  output logic [AW-1:0]    idx,
  output logic [CW-1:0]    cnt
);
  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hits[i]) idx = AW'(i);
    end
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt = cnt + CW'(hits[i]);
    end
  end

  assign any = |hits;
endmodule

// File: rtl/cam_match_unit.sv
module cam_match_unit
  import cam_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  parameter logic [DEPTH*WIDTH-1:0] INIT_WORDS = '0,
  parameter logic [DEPTH-1:0] INIT_VALID = '0,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             clr_en,
  input  logic [AW-1:0]    clr_addr,
  input  logic             clr_all,
  input  logic             srch_valid,
  output logic             srch_ready,
  input  logic [WIDTH-1:0] srch_key,
  input  logic             srch_multi,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_hit,
  output logic [AW-1:0]    res_addr,
  output logic [DEPTH-1:0] res_vec,
  output logic [CW-1:0]    res_count
);
  logic [DEPTH*WIDTH-1:0] ent_data;
  logic [DEPTH-1:0]       ent_valid;
  logic [DEPTH-1:0]       hits;
  logic                   any;
  logic [AW-1:0]          idx;
  logic [CW-1:0]          cnt;
  logic [DEPTH-1:0]       vec_nxt;
  logic [CW-1:0]          cnt_nxt;
  logic                   accept;
  match_mode_e            mode;

  cam_store #(
    .DEPTH(DEPTH), .WIDTH(WIDTH),
    .INIT_WORDS(INIT_WORDS), .INIT_VALID(INIT_VALID)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_en(clr_en), .clr_addr(clr_addr), .clr_all(clr_all),
    .ent_data(ent_data), .ent_valid(ent_valid)
  );

  cam_compare #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_cmp (
    .ent_data(ent_data), .ent_valid(ent_valid), .key(srch_key), .hits(hits)
  );

  cam_encode #(.DEPTH(DEPTH)) u_enc (
    .hits(hits), .any(any), .idx(idx), .cnt(cnt)
  );

  assign mode       = srch_multi ? MATCH_MULTI : MATCH_SINGLE;
  assign srch_ready = !res_valid || res_ready;
  assign accept     = srch_valid && srch_ready;

  always_comb begin
    if (mode == MATCH_MULTI) begin
      vec_nxt = hits;
      cnt_nxt = cnt;
    end else begin
      vec_nxt = any ? (DEPTH'(1) << idx) : '0;
      cnt_nxt = CW'(any);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_addr  <= '0;
      res_vec   <= '0;
      res_count <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_hit   <= any;
      res_addr  <= idx;
      res_vec   <= vec_nxt;
      res_count <= cnt_nxt;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R9: accepted key yields a result on the next cycle
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid && srch_ready) |=> res_valid);

  // R10: stalled result is held and no key is taken
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_vec)
      && $stable(res_addr) && $stable(res_count) && $stable(res_hit)));

  a_r10_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !srch_ready);

  // R5: count agrees with the reported vector
  a_r5_count: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_count == CW'($countones(res_vec))));

  // R6: hit flag agrees with the vector
  a_r6_hit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (res_vec != '0)));

  // R4: single-mode results carry at most one bit
  logic multi_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      multi_q <= 1'b0;
    else if (accept) multi_q <= srch_multi;
  end
  a_r4_single_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !multi_q) |-> $onehot0(res_vec));
endmodule

// File: tb/cam_match_unit_bench.sv
`timescale 1ns/1ps
module cam_match_unit_bench;
  localparam logic [127:0] PRE_WORDS = {8'h22, 112'h0, 8'h11};
  localparam logic [15:0]  PRE_VALID = 16'h8001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, clr_en = 1'b0, clr_all = 1'b0;
  logic [3:0] wr_addr = '0, clr_addr = '0;
  logic [7:0] wr_data = '0, srch_key = '0;
  logic srch_valid = 1'b0, srch_multi = 1'b0, res_ready = 1'b1;
  logic srch_ready, res_valid, res_hit;
  logic [3:0] res_addr;
  logic [15:0] res_vec;
  logic [4:0] res_count;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cam_match_unit #(.INIT_WORDS(PRE_WORDS), .INIT_VALID(PRE_VALID)) u_cam_match_unit (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_en(clr_en), .clr_addr(clr_addr), .clr_all(clr_all),
    .srch_valid(srch_valid), .srch_ready(srch_ready), .srch_key(srch_key),
    .srch_multi(srch_multi), .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .res_addr(res_addr), .res_vec(res_vec), .res_count(res_count)
  );

  // behavioural reference
  logic [7:0] m_data [16];
  bit         m_val  [16];
  bit         m_rv, m_hit;
  int         m_addr, m_cnt;
  logic [15:0] m_vec;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        m_data[i] = PRE_WORDS[i*8 +: 8];
        m_val[i]  = PRE_VALID[i];
      end
      m_rv = 0; m_hit = 0; m_addr = 0; m_cnt = 0; m_vec = '0;
    end else begin
      if (srch_valid && (!m_rv || res_ready)) begin
        m_rv = 1; m_hit = 0; m_addr = 0; m_cnt = 0; m_vec = '0;
        for (int i = 0; i < 16; i++) begin
          if (m_val[i] && m_data[i] == srch_key) begin
            if (!m_hit) begin
              m_hit = 1; m_addr = i; m_vec[i] = 1'b1; m_cnt = 1;
            end else if (srch_multi) begin
              m_vec[i] = 1'b1; m_cnt++;
            end
          end
        end
      end else if (res_ready) begin
        m_rv = 0;
      end
      if (clr_all) begin
        for (int i = 0; i < 16; i++) m_val[i] = 0;
      end else begin
        if (wr_en) begin m_data[wr_addr] = wr_data; m_val[wr_addr] = 1; end
        if (clr_en) m_val[clr_addr] = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(srch_ready == (!m_rv || res_ready), "R10 srch_ready", srch_ready, int'(!m_rv || res_ready));
      check(res_valid == m_rv,  "R9 res_valid", res_valid, m_rv);
      check(res_hit == m_hit,   "R4 res_hit",   res_hit,   m_hit);
      check(res_addr == m_addr, "R4 res_addr",  res_addr,  m_addr);
      check(res_vec == m_vec,   "R5 res_vec",   res_vec,   m_vec);
      check(res_count == m_cnt, "R5 res_count", res_count, m_cnt);
    end
  end

  task automatic do_write(input int a, input logic [7:0] d);
    wr_en = 1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_search(input logic [7:0] k, input bit multi);
    srch_valid = 1; srch_key = k; srch_multi = multi;
    @(negedge clk);
    srch_valid = 0;
    #2;
  endtask

  task automatic expect_res(input string tag, input bit hit, input int addr,
                            input logic [15:0] vec, input int cnt);
    check(res_valid == 1'b1, tag, res_valid, 1);
    check(res_hit == hit, tag, res_hit, hit);
    check(res_addr == addr, tag, res_addr, addr);
    check(res_vec == vec, tag, res_vec, vec);
    check(res_count == cnt, tag, res_count, cnt);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check(res_valid == 0, "R1 res_valid", res_valid, 0);
    check(srch_ready == 1, "R1 srch_ready", srch_ready, 1);
    check(res_vec == 0 && res_count == 0 && res_addr == 0 && !res_hit, "R1 fields", res_vec, 0);
    @(negedge clk);
    // R11 preloaded slots
    do_search(8'h22, 1); expect_res("R11 preload slot15", 1, 15, 16'h8000, 1);
    do_search(8'h11, 0); expect_res("R11 preload slot0", 1, 0, 16'h0001, 1);
    // R3 invalid slots holding zero never match
    do_search(8'h00, 1); expect_res("R3 invalid zero", 0, 0, 16'h0000, 0);
    // R5 / R4 several matches
    do_write(3, 8'h40); do_write(5, 8'h40); do_write(9, 8'h40);
    do_search(8'h40, 1); expect_res("R5 multi", 1, 3, 16'h0228, 3);
    do_search(8'h40, 0); expect_res("R4 single", 1, 3, 16'h0008, 1);
    // R2 same-cycle write is not seen, next cycle it is
    wr_en = 1; wr_addr = 4'd7; wr_data = 8'h77;
    srch_valid = 1; srch_key = 8'h77; srch_multi = 0;
    @(negedge clk);
    wr_en = 0; srch_valid = 0; #2;
    expect_res("R2 same cycle", 0, 0, 16'h0000, 0);
    do_search(8'h77, 0); expect_res("R2 next cycle", 1, 7, 16'h0080, 1);
    // R6 no match
    do_search(8'h99, 0); expect_res("R6 miss single", 0, 0, 16'h0000, 0);
    do_search(8'h99, 1); expect_res("R6 miss multi", 0, 0, 16'h0000, 0);
    // R7 single clear, and clear beating a write
    clr_en = 1; clr_addr = 4'd5; @(negedge clk); clr_en = 0;
    do_search(8'h40, 1); expect_res("R7 clear one", 1, 3, 16'h0208, 2);
    clr_en = 1; clr_addr = 4'd9; wr_en = 1; wr_addr = 4'd9; wr_data = 8'h40;
    @(negedge clk); clr_en = 0; wr_en = 0;
    do_search(8'h40, 1); expect_res("R7 clear wins", 1, 3, 16'h0008, 1);
    // R10 back-pressure
    res_ready = 0;
    do_search(8'h40, 1);
    srch_valid = 1; srch_key = 8'h77; srch_multi = 1;
    repeat (3) @(negedge clk);
    #2;
    check(srch_ready == 0, "R10 stall ready", srch_ready, 0);
    expect_res("R10 held", 1, 3, 16'h0008, 1);
    res_ready = 1;
    @(negedge clk);
    srch_valid = 0; #2;
    expect_res("R10 released", 1, 7, 16'h0080, 1);
    @(negedge clk);
    #2;
    check(res_valid == 0, "R10 drained", res_valid, 0);
    // R8 clear-all beats a write
    clr_all = 1; wr_en = 1; wr_addr = 4'd2; wr_data = 8'h40;
    @(negedge clk); clr_all = 0; wr_en = 0;
    do_search(8'h40, 1); expect_res("R8 clear all", 0, 0, 16'h0000, 0);
    do_search(8'h22, 1); expect_res("R8 preload gone", 0, 0, 16'h0000, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule